// File: doc/BRIEF.md
# Ticket Lock Arbiter

This block is a shared mutual-exclusion unit for a fixed set of requesters. It grants the lock in strict arrival order using two wrapping counters. One counts tickets handed out and the other counts releases. A requester takes the lock with a single atomic take-a-number operation: it pulses its acquire line, and one cycle later it receives a ticket. That ticket is the value the issue counter held, and the counter steps past it in the same operation.

After it has a ticket, the requester spins on a read-only compare port. It presents its ticket and watches a per-requester "is owner" flag. That flag is true exactly when the release counter equals the ticket, so waiting costs no read-modify-write traffic. The owner finishes by pulsing the release line, which hands the lock to the next ticket in line. Several acquires in one cycle are ordered by a fixed priority, lowest requester index first, and they receive consecutive tickets. The unit also reports whether the lock is held, how many requesters are queued behind the owner, and an error pulse when a release arrives while the lock is free.

Top module: `ticket_lock_unit`

## Requirements
- R1: After a synchronous active-low reset, `serving` and `next_ticket` are 0, `held` is 0, `wait_cnt` is 0, and no `acq_ack` or `rel_err` bit is set.
- R2: A lone acquire from requester i sets `acq_ack[i]` for exactly the following cycle, with `acq_ticket` slice i (bits i*TKT_W upward) equal to the `next_ticket` value before the acquire, and `next_ticket` grows by one.
- R3: When k acquire bits are set in one cycle, the requesters receive k consecutive tickets starting at the prior `next_ticket`, the lowest set index taking the smallest, and `next_ticket` grows by k.
- R4: `poll_owner[i]` is 1 in the same cycle exactly when slice i of `poll_ticket` equals `serving`.
- R5: A release while `held` is 1 raises `serving` by one on the next clock edge, so the owner flag moves to the next ticket.
- R6: A release while `held` is 0 leaves `serving` unchanged and raises `rel_err` for exactly one cycle.
- R7: `held` is 1 exactly when `next_ticket` differs from `serving`.
- R8: `wait_cnt` equals `next_ticket - serving - 1` (modulo 2^TKT_W) while `held` is 1, and 0 otherwise.
- R9: Both counters wrap modulo 2^TKT_W, and tickets issued across the wrap point are still served in order.
- R10: Changing `poll_ticket` never alters `serving`, `next_ticket`, `held` or `wait_cnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_req | input | NUM_REQ | One-cycle acquire pulse per requester |
| acq_ack | output | NUM_REQ | Ticket-valid pulse, one cycle after the acquire |
| acq_ticket | output | NUM_REQ*TKT_W | Ticket per requester, slice i at bits i*TKT_W upward |
| rel_req | input | 1 | Release pulse from the current owner |
| rel_err | output | 1 | One-cycle pulse after a release while the lock is free |
| poll_ticket | input | NUM_REQ*TKT_W | Ticket each requester is polling with |
| poll_owner | output | NUM_REQ | Combinational match of each polled ticket against the release counter |
| serving | output | TKT_W | Release counter, the ticket now holding the lock |
| next_ticket | output | TKT_W | Request counter, the next ticket to be issued |
| held | output | 1 | Lock currently owned |
| wait_cnt | output | TKT_W | Number of requesters queued behind the owner |

## Verification
The acquire path is driven with a lone request from a middle index and with a sparse mask that skips one requester. Together these separate a correct priority prefix from one that ignores gaps or reverses the order. A full four-way burst is placed so that it straddles the counter wrap, which exposes any comparison or subtraction that is not modular. Releases are applied both in sequence while the lock is held and while it is free, which distinguishes a true handoff from an error case that is silently ignored. Polls are held with matching and non-matching tickets over several cycles to show that the compare port is read-only.

// File: rtl/ticket_lock_pkg.sv
// Package: shared constants, types and helpers for the ticket lock unit.
// Assumes no instance serves more than MAX_REQ requesters.
package ticket_lock_pkg;

    // Largest requester count the helper function accepts.
    localparam int unsigned MAX_REQ = 32;

    // Outcome of a release request as judged in the current cycle.
    typedef enum logic [1:0] {
        REL_IDLE = 2'd0,
        REL_STEP = 2'd1,
        REL_BAD  = 2'd2
    } rel_kind_e;

    // Count the set bits of v strictly below position idx (priority rank).
    function automatic int unsigned ones_below(input logic [MAX_REQ-1:0] v,
                                               input int unsigned idx);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned j = 0; j < MAX_REQ; j++) begin
            if (j < idx) begin
                cnt = cnt + int'(v[j]);
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/tkt_issue.sv
// Module: tkt_issue
// Hands out tickets. Every requester that pulses acquire in a cycle gets
// the request counter plus its rank among the set bits (lowest index first).
// The counter advances by the number of set bits. Tickets and acks are
// registered, so they appear one cycle after the acquire.
// Assumes NUM_REQ <= MAX_REQ and that a requester does not re-acquire
// while it still holds an outstanding ticket.
module tkt_issue
    import ticket_lock_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    parameter int unsigned TKT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       acq_req,
    output logic [TKT_W-1:0]         req_cnt,
    output logic [NUM_REQ-1:0]       acq_ack,
    output logic [NUM_REQ*TKT_W-1:0] acq_ticket
);

    localparam int unsigned TW = NUM_REQ * TKT_W;

    logic [MAX_REQ-1:0]        req_wide;
    logic [TKT_W-1:0]          grant_total;
    logic [TKT_W-1:0]          rank   [NUM_REQ];
    logic [TKT_W-1:0]          tkt_nx [NUM_REQ];
    logic [TW-1:0]             tkt_q;

    // Widen the request mask for the shared rank helper.
    assign req_wide = MAX_REQ'(acq_req);

    // Number of tickets issued this cycle.
    assign grant_total = TKT_W'($countones(acq_req));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_rank
            // Rank of requester gi among this cycle's acquires.
            assign rank[gi]   = TKT_W'(ones_below(req_wide, gi));
            // Candidate ticket for requester gi.
            assign tkt_nx[gi] = req_cnt + rank[gi];

            // Capture the ticket for a requester that acquired this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tkt_q[gi*TKT_W +: TKT_W] <= '0;
                end else if (acq_req[gi]) begin
                    tkt_q[gi*TKT_W +: TKT_W] <= tkt_nx[gi];
                end
            end
        end
    endgenerate

    // Request counter: atomically steps past every ticket handed out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cnt <= '0;
        end else begin
            req_cnt <= req_cnt + grant_total;
        end
    end

    // Acknowledge pulse, one cycle after each acquire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_ack <= '0;
        end else begin
            acq_ack <= acq_req;
        end
    end

    assign acq_ticket = tkt_q;

endmodule

// File: rtl/tkt_release.sv
// Module: tkt_release
// Keeps the release counter. A release while the lock is held steps the
// counter and hands ownership to the next ticket. A release while the lock
// is free changes nothing and raises a one-cycle error pulse.
// Assumes only the current owner drives the release line.
module tkt_release
    import ticket_lock_pkg::*;
#(
    parameter int unsigned TKT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_req,
    input  logic             held,
    output logic [TKT_W-1:0] rel_cnt,
    output logic             rel_err
);

    rel_kind_e kind;

    // Classify this cycle's release against the current ownership.
    always_comb begin
        if (!rel_req) begin
            kind = REL_IDLE;
        end else if (held) begin
            kind = REL_STEP;
        end else begin
            kind = REL_BAD;
        end
    end

    // Release counter: moves only on a legal release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_cnt <= '0;
        end else if (kind == REL_STEP) begin
            rel_cnt <= rel_cnt + 1'b1;
        end
    end

    // Error pulse for a release that arrives while the lock is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_err <= 1'b0;
        end else begin
            rel_err <= (kind == REL_BAD);
        end
    end

endmodule

// File: rtl/tkt_status.sv
// Module: tkt_status
// Derives the lock status from the two counters: whether the lock is held,
// the length of the queue behind the owner, and the per-requester owner
// match for the read-only poll port. It is purely combinational.
// Assumes fewer than 2^TKT_W tickets are outstanding at any time.
module tkt_status #(
    parameter int unsigned NUM_REQ = 4,
    parameter int unsigned TKT_W   = 4
) (
    input  logic [TKT_W-1:0]         req_cnt,
    input  logic [TKT_W-1:0]         rel_cnt,
    input  logic [NUM_REQ*TKT_W-1:0] poll_ticket,
    output logic                     held,
    output logic [TKT_W-1:0]         wait_cnt,
    output logic [NUM_REQ-1:0]       poll_owner
);

    logic [TKT_W-1:0] outstanding;

    // Tickets issued but not yet released, modulo the counter width.
    assign outstanding = req_cnt - rel_cnt;

    // Held whenever any issued ticket is not yet released.
    assign held = (outstanding != '0);

    // Queue length excludes the owner itself.
    always_comb begin
        if (held) begin
            wait_cnt = outstanding - 1'b1;
        end else begin
            wait_cnt = '0;
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < NUM_REQ; gp++) begin : g_poll
            // Read-only ownership compare for requester gp.
            assign poll_owner[gp] = (poll_ticket[gp*TKT_W +: TKT_W] == rel_cnt);
        end
    endgenerate

endmodule

// File: rtl/ticket_lock_unit.sv
// Module: ticket_lock_unit (top)
// First-come first-served lock arbiter built from a request counter and a
// release counter. An acquire is a fetch-and-increment of the request counter.
// Waiters poll a read-only compare port. A release steps the release counter.
// Assumes each requester holds at most one ticket and that
// NUM_REQ < 2^TKT_W, so the counters never alias outstanding tickets.
module ticket_lock_unit #(
    parameter int unsigned NUM_REQ = 4,
    parameter int unsigned TKT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       acq_req,
    output logic [NUM_REQ-1:0]       acq_ack,
    output logic [NUM_REQ*TKT_W-1:0] acq_ticket,
    input  logic                     rel_req,
    output logic                     rel_err,
    input  logic [NUM_REQ*TKT_W-1:0] poll_ticket,
    output logic [NUM_REQ-1:0]       poll_owner,
    output logic [TKT_W-1:0]         serving,
    output logic [TKT_W-1:0]         next_ticket,
    output logic                     held,
    output logic [TKT_W-1:0]         wait_cnt
);

    logic [TKT_W-1:0] req_cnt;
    logic [TKT_W-1:0] rel_cnt;
    logic             held_int;

    // Ticket issue front end with fixed priority.
    tkt_issue #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_req    (acq_req),
        .req_cnt    (req_cnt),
        .acq_ack    (acq_ack),
        .acq_ticket (acq_ticket)
    );

    // Release counter and misuse detection.
    tkt_release #(.TKT_W(TKT_W)) u_release (
        .clk     (clk),
        .rst_n   (rst_n),
        .rel_req (rel_req),
        .held    (held_int),
        .rel_cnt (rel_cnt),
        .rel_err (rel_err)
    );

    // Status and poll compare.
    tkt_status #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_status (
        .req_cnt     (req_cnt),
        .rel_cnt     (rel_cnt),
        .poll_ticket (poll_ticket),
        .held        (held_int),
        .wait_cnt    (wait_cnt),
        .poll_owner  (poll_owner)
    );

    assign serving     = rel_cnt;
    assign next_ticket = req_cnt;
    assign held        = held_int;

endmodule

// File: rtl/ticket_lock_chk.sv
// Module: ticket_lock_chk
// Temporal checks on the ticket lock ports, attached to every instance of
// the top module through the bind statement at the end of this file.
module ticket_lock_chk #(
    parameter int unsigned NUM_REQ = 4,
    parameter int unsigned TKT_W   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_REQ-1:0]       acq_req,
    input logic [NUM_REQ-1:0]       acq_ack,
    input logic [NUM_REQ*TKT_W-1:0] acq_ticket,
    input logic                     rel_req,
    input logic                     rel_err,
    input logic [NUM_REQ*TKT_W-1:0] poll_ticket,
    input logic [NUM_REQ-1:0]       poll_owner,
    input logic [TKT_W-1:0]         serving,
    input logic [TKT_W-1:0]         next_ticket,
    input logic                     held,
    input logic [TKT_W-1:0]         wait_cnt
);

    // R1: counters are cleared by the reset cycle.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (serving == '0 && next_ticket == '0 && acq_ack == '0 && !rel_err));

    // R2: every acquire is acknowledged exactly one cycle later.
    p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (acq_ack == $past(acq_req)));

    // R3: the request counter advances by the number of acquires.
    p_count_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (next_ticket == TKT_W'($past(next_ticket) + TKT_W'($countones($past(acq_req))))));

    // R5: a legal release moves ownership to the next ticket.
    p_release_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rel_req) && $past(held)) |-> (serving == TKT_W'($past(serving) + 1'b1)));

    // R6: a release on a free lock leaves the counter and pulses the error.
    p_bad_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rel_req) && !$past(held)) |-> (rel_err && $stable(serving)));

    // R6: the error pulse has no other cause.
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |-> ($past(rel_req) && !$past(held)));

    // R8: no queue is reported while the lock is free.
    p_free_no_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> (wait_cnt == '0));

    // R5: serving never moves without a release.
    p_serving_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rel_req)) |-> $stable(serving));

    genvar gk;
    generate
        for (gk = 0; gk < NUM_REQ; gk++) begin : g_chk_poll
            // R4: the owner flag tracks the release counter.
            p_poll_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
                poll_owner[gk] == (poll_ticket[gk*TKT_W +: TKT_W] == serving));
        end
    endgenerate

    // Ticket values are covered by the bench.
    logic unused_ok;
    assign unused_ok = ^acq_ticket;

endmodule

bind ticket_lock_unit ticket_lock_chk #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_req     (acq_req),
    .acq_ack     (acq_ack),
    .acq_ticket  (acq_ticket),
    .rel_req     (rel_req),
    .rel_err     (rel_err),
    .poll_ticket (poll_ticket),
    .poll_owner  (poll_owner),
    .serving     (serving),
    .next_ticket (next_ticket),
    .held        (held),
    .wait_cnt    (wait_cnt)
);

// File: tb/tb_ticket_lock_unit.sv
`timescale 1ns/1ps
// Directed bench for ticket_lock_unit: one task per scenario.
module tb_ticket_lock_unit;

    localparam int NR = 4;
    localparam int TW = 4;

    logic            clk;
    logic            rst_n;
    logic [NR-1:0]   acq_req;
    logic [NR-1:0]   acq_ack;
    logic [NR*TW-1:0] acq_ticket;
    logic            rel_req;
    logic            rel_err;
    logic [NR*TW-1:0] poll_ticket;
    logic [NR-1:0]   poll_owner;
    logic [TW-1:0]   serving;
    logic [TW-1:0]   next_ticket;
    logic            held;
    logic [TW-1:0]   wait_cnt;

    int checks;
    int failures;
    bit done;

    // Bench model of the two counters.
    int exp_next;
    int exp_serv;

    ticket_lock_unit #(.NUM_REQ(NR), .TKT_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .acq_ack(acq_ack),
        .acq_ticket(acq_ticket), .rel_req(rel_req), .rel_err(rel_err),
        .poll_ticket(poll_ticket), .poll_owner(poll_owner), .serving(serving),
        .next_ticket(next_ticket), .held(held), .wait_cnt(wait_cnt)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int tkt(input int i);
        return int'(acq_ticket[i*TW +: TW]);
    endfunction

    // Compare status outputs against the bench model.
    task automatic chk_status(input string req);
        int outst;
        int ew;
        outst = (exp_next - exp_serv) & 15;
        ew = (outst != 0) ? outst - 1 : 0;
        chk(int'(next_ticket) == exp_next, req, "next_ticket", next_ticket, exp_next);
        chk(int'(serving) == exp_serv, req, "serving", serving, exp_serv);
        chk(held == (outst != 0), "R7", "held", held, int'(outst != 0));
        chk(int'(wait_cnt) == ew, "R8", "wait_cnt", wait_cnt, ew);
    endtask

    // Pulse an acquire mask for one cycle and check the issued tickets.
    task automatic do_acquire(input logic [NR-1:0] mask, input string req);
        int base;
        int rank;
        base = exp_next;
        @(negedge clk);
        acq_req = mask;
        @(posedge clk);
        #1;
        rank = 0;
        for (int i = 0; i < NR; i++) begin
            chk(acq_ack[i] == mask[i], req, "acq_ack bit", acq_ack[i], mask[i]);
            if (mask[i]) begin
                chk(tkt(i) == ((base + rank) & 15), req, "ticket", tkt(i), (base + rank) & 15);
                rank++;
            end
        end
        exp_next = (base + rank) & 15;
        chk_status(req);
        @(negedge clk);
        acq_req = '0;
    endtask

    // Pulse a release and check handoff or error.
    task automatic do_release(input string req);
        bit was_held;
        was_held = (exp_next != exp_serv);
        @(negedge clk);
        rel_req = 1'b1;
        @(posedge clk);
        #1;
        if (was_held) exp_serv = (exp_serv + 1) & 15;
        chk(rel_err == !was_held, was_held ? "R5" : "R6", "rel_err", rel_err, int'(!was_held));
        chk_status(req);
        @(negedge clk);
        rel_req = 1'b0;
        @(posedge clk);
        #1;
        chk(rel_err == 1'b0, "R6", "rel_err one cycle", rel_err, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        acq_req = '0;
        rel_req = 1'b0;
        poll_ticket = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        exp_next = 0;
        exp_serv = 0;
        // R1
        chk_status("R1");
        chk(acq_ack == '0, "R1", "acq_ack", acq_ack, 0);
        chk(rel_err == 1'b0, "R1", "rel_err", rel_err, 0);
    endtask

    task automatic t_release_free();
        do_release("R6");
    endtask

    task automatic t_single();
        do_acquire(4'b0100, "R2");
    endtask

    // R4 and R10: polls match serving and leave state untouched.
    task automatic t_poll();
        @(negedge clk);
        poll_ticket = '0;
        poll_ticket[2*TW +: TW] = 4'(exp_serv);
        poll_ticket[1*TW +: TW] = 4'(exp_serv + 3);
        #1;
        chk(poll_owner[2] == 1'b1, "R4", "owner match", poll_owner[2], 1);
        chk(poll_owner[1] == 1'b0, "R4", "owner mismatch", poll_owner[1], 0);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            poll_ticket[3*TW +: TW] = 4'(c);
            #1;
            chk_status("R10");
        end
    endtask

    task automatic t_burst();
        do_acquire(4'b1011, "R3");
    endtask

    // R5 with R4: each release moves ownership to the next ticket.
    task automatic t_chain();
        while (exp_next != exp_serv) begin
            do_release("R5");
            @(negedge clk);
            poll_ticket[0] = 1'b0;
            poll_ticket[0*TW +: TW] = 4'(exp_serv);
            #1;
            chk(poll_owner[0] == 1'b1, "R4", "owner after handoff", poll_owner[0], 1);
        end
        do_release("R6");
    endtask

    // R9: run the counters up to the wrap and issue a burst across it.
    task automatic t_wrap();
        while (exp_next != 14) begin
            do_acquire(4'b0001, "R2");
            do_release("R5");
        end
        do_acquire(4'b1111, "R9");
        while (exp_next != exp_serv) begin
            do_release("R9");
        end
        chk(int'(serving) == 2, "R9", "serving after wrap", serving, 2);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        checks = 0;
        failures = 0;
        done = 1'b0;
        t_reset();
        t_release_free();
        t_single();
        t_poll();
        t_burst();
        t_chain();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule